// File: doc/BRIEF.md
# Cell Header Error Check Unit

This unit sits in the receive path of a fixed-length cell stream. Cells are 53 bytes long and arrive one byte per accepted beat, with a start flag on the first byte and the source port number beside it. The unit keeps the byte position within the current cell. It runs a CRC over the first four header bytes and compares the result with the fifth byte. A 2-bit mode input then decides what happens to the cell. Every byte leaves on the output stream exactly one cycle after it entered.

In the regenerating mode (code 00), a cell is never dropped. A header check mismatch adds one to a saturating error counter kept for the cell's port. The fifth byte is then replaced by a freshly computed check byte. In every other mode, a cell whose check byte is wrong is marked for discard: a drop flag goes out from the fifth byte to the end of the cell. In these modes the fifth byte passes through unchanged. The per-port counters are read one at a time, and a read clears the counter it reads.

Top module: `hec_check_unit`

## Requirements
- R1: Every accepted input byte appears on `out_data` with `out_valid` high exactly one clock later. A cycle with no accepted byte gives `out_valid` low one clock later. Bytes other than the fifth of a cell leave unchanged.
- R2: A byte with `in_sop` high, arriving while no cell is in progress, begins a cell. The following 52 accepted bytes belong to that cell whatever `in_sop` carries. `out_sop` is high on the output beat of the first byte only.
- R3: A valid byte that arrives with `in_sop` low while no cell is in progress is discarded and produces no output beat.
- R4: The expected check byte is a CRC-8 over header bytes 1 to 4, XORed with 0x55. The CRC uses polynomial x^8+x^2+x+1, starts from zero and takes each byte most significant bit first. A header of 00 00 00 01 therefore gives 0x52.
- R5: In mode 00, the fifth output byte of a cell is the expected check byte from R4, whatever byte was received.
- R6: In mode 00, `out_drop` stays low for every beat of every cell.
- R7: In mode 00, a fifth byte that differs from the expected check byte adds one to the counter of the port sampled with the cell's first byte. A matching fifth byte leaves every counter unchanged.
- R8: In modes 01, 10 and 11, a mismatching fifth byte passes through unchanged. `out_drop` is then high on the output beats of byte 5 through byte 53 and low on bytes 1 to 4. No counter changes.
- R9: In modes 01, 10 and 11, a cell with a matching fifth byte leaves with `out_drop` low throughout and all bytes unchanged.
- R10: An error counter at its all-ones value stays there on further mismatches.
- R11: When `rd_en` is high, `rd_count` shows the value of the counter selected by `rd_port` one clock later, and that counter is cleared. A mismatch counted in the same cycle leaves the counter at one after the read.
- R12: After reset, `out_valid` is low, no cell is in progress and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Check mode; 00 regenerates, others filter (sampled with byte 5) |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | First byte of a cell |
| in_port | input | PORT_W | Source port, sampled with the first byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | Output byte is first of a cell |
| out_data | output | 8 | Output byte |
| out_drop | output | 1 | Cell marked for discard (from byte 5 onward) |
| rd_en | input | 1 | Counter read request |
| rd_port | input | PORT_W | Port whose counter is read |
| rd_count | output | CNT_W | Counter value returned by the last read |

## Verification
The bench builds the unit with 4 ports and 3-bit counters. With these values, a counter saturates after only seven bad cells, so the bench can check that it holds at all ones within a short run. The bench uses a small port range, so random cells often hit the same counter. This lets it check that errors accumulate and that a clear-on-read coincides with a new error. It keeps the 53-byte cell length, so mid-cell start flags, idle gaps and all four modes are covered on full cells.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 5;
    localparam int POS_W      = $clog2(CELL_BYTES);

    localparam logic [7:0] HEC_POLY  = 8'h07;
    localparam logic [7:0] HEC_COSET = 8'h55;

    typedef enum logic [1:0] {
        MODE_REGEN  = 2'b00,
        MODE_FILT_1 = 2'b01,
        MODE_FILT_2 = 2'b10,
        MODE_FILT_3 = 2'b11
    } hec_mode_e;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic       drop;
        logic [7:0] data;
    } beat_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] c;
        c = crc ^ din;
        for (int k = 0; k < 8; k++) begin
            c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/hec_cell_tracker.sv
module hec_cell_tracker
    import hec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic             take,
    output logic             active,
    output logic [POS_W-1:0] idx
);
    localparam logic [POS_W-1:0] LAST_IDX = POS_W'(CELL_BYTES - 1);

    logic [POS_W-1:0] pos_q;
    logic             active_q;

    assign take   = in_valid && (active_q || in_sop);
    assign idx    = active_q ? pos_q : '0;
    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (take) begin
            if (idx == LAST_IDX) begin
                active_q <= 1'b0;
                pos_q    <= '0;
            end else begin
                active_q <= 1'b1;
                pos_q    <= idx + POS_W'(1);
            end
        end
    end

    // R2: a start flag inside a cell does not restart the position count
    p_sop_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (active_q && in_valid && pos_q != LAST_IDX) |=> (active_q && pos_q == $past(pos_q) + POS_W'(1)));

endmodule

// File: rtl/hec_crc_acc.sv
module hec_crc_acc
    import hec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [POS_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [7:0]       hec_exp
);
    localparam logic [POS_W-1:0] HEC_IDX = POS_W'(HDR_BYTES - 1);

    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (take) begin
            if (idx == '0)
                crc_q <= crc8_step(8'h00, din);
            else if (idx < HEC_IDX)
                crc_q <= crc8_step(crc_q, din);
        end
    end

    assign hec_exp = crc_q ^ HEC_COSET;

endmodule

// File: rtl/hec_err_counters.sv
module hec_err_counters #(
    parameter int NUM_PORTS = 16,
    parameter int CNT_W     = 16,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic [PORT_W-1:0] inc_port,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_port,
    output logic [CNT_W-1:0]  rd_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]     cnt [NUM_PORTS];
    logic [NUM_PORTS-1:0] hit_inc;
    logic [NUM_PORTS-1:0] hit_rd;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic [CNT_W-1:0] base;

        assign hit_inc[g] = inc && (inc_port == PORT_W'(g));
        assign hit_rd[g]  = rd_en && (rd_port == PORT_W'(g));
        assign base       = hit_rd[g] ? '0 : cnt[g];

        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (hit_inc[g] && base != CNT_MAX)
                cnt[g] <= base + CNT_W'(1);
            else
                cnt[g] <= base;
        end

        // R10: a full counter never wraps
        p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
            (cnt[g] == CNT_MAX && !hit_rd[g]) |=> (cnt[g] == CNT_MAX));

        // R11: a read with no coincident error leaves the counter at zero
        p_read_clear_r11: assert property (@(posedge clk) disable iff (rst)
            (hit_rd[g] && !hit_inc[g]) |=> (cnt[g] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_count <= '0;
        else if (rd_en)
            rd_count <= cnt[rd_port];
    end

endmodule

// File: rtl/hec_check_unit.sv
module hec_check_unit
    import hec_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int CNT_W     = 16,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [PORT_W-1:0] in_port,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_data,
    output logic              out_drop,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_port,
    output logic [CNT_W-1:0]  rd_count
);
    localparam logic [POS_W-1:0] HEC_IDX = POS_W'(HDR_BYTES - 1);

    logic             take;
    logic             trk_active;
    logic [POS_W-1:0] idx;
    logic [7:0]       hec_exp;
    logic [PORT_W-1:0] port_q;
    logic             drop_q;
    logic             at_hec;
    logic             regen;
    logic             bad;
    logic             count_err;
    beat_t            beat_q;

    hec_cell_tracker u_trk (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .take     (take),
        .active   (trk_active),
        .idx      (idx)
    );

    hec_crc_acc u_crc (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .idx     (idx),
        .din     (in_data),
        .hec_exp (hec_exp)
    );

    assign at_hec    = take && (idx == HEC_IDX);
    assign regen     = (hec_mode_e'(mode) == MODE_REGEN);
    assign bad       = (in_data != hec_exp);
    assign count_err = at_hec && bad && regen;

    hec_err_counters #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .PORT_W    (PORT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (count_err),
        .inc_port (port_q),
        .rd_en    (rd_en),
        .rd_port  (rd_port),
        .rd_count (rd_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
            drop_q <= 1'b0;
        end else if (take) begin
            if (idx == '0) begin
                port_q <= in_port;
                drop_q <= 1'b0;
            end else if (idx == HEC_IDX) begin
                drop_q <= bad && !regen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= take;
            beat_q.first <= take && (idx == '0);
            beat_q.data  <= (at_hec && regen) ? hec_exp : in_data;
            if (at_hec)
                beat_q.drop <= bad && !regen;
            else
                beat_q.drop <= take && (idx > HEC_IDX) && drop_q;
        end
    end

    assign out_valid = beat_q.valid;
    assign out_sop   = beat_q.first;
    assign out_data  = beat_q.data;
    assign out_drop  = beat_q.drop;

    // R1: an accepted byte leaves one cycle later
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && trk_active) |=> out_valid);

    // R2: a start byte outside a cell opens a cell on the output
    p_cell_start_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && !trk_active) |=> (out_valid && out_sop));

    // R3: stray bytes between cells give no output
    p_idle_discard_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sop && !trk_active) |=> !out_valid);

    // R6: the regenerating mode never marks a cell for discard
    p_no_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (at_hec && regen) |=> !out_drop);

endmodule

// File: tb/hec_check_unit_test.sv
`timescale 1ns/1ps
module hec_check_unit_test;

    localparam int NP   = 4;
    localparam int CW   = 3;
    localparam int PW   = 2;
    localparam int MAXC = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode;
    logic          in_valid;
    logic          in_sop;
    logic [PW-1:0] in_port;
    logic [7:0]    in_data;
    logic          out_valid;
    logic          out_sop;
    logic [7:0]    out_data;
    logic          out_drop;
    logic          rd_en;
    logic [PW-1:0] rd_port;
    logic [CW-1:0] rd_count;

    int checks = 0;
    int fails  = 0;
    int model_cnt [NP];

    always #2.5 clk = ~clk;

    hec_check_unit #(.NUM_PORTS(NP), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .mode(mode),
        .in_valid(in_valid), .in_sop(in_sop), .in_port(in_port), .in_data(in_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data), .out_drop(out_drop),
        .rd_en(rd_en), .rd_port(rd_port), .rd_count(rd_count)
    );

    function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
        logic [7:0] c = 8'h00;
        for (int b = 3; b >= 0; b--) begin
            c = c ^ hdr[8*b +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c ^ 8'h55;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_cell(input int port, input logic [1:0] md, input logic [31:0] hdr,
                             input bit corrupt, input bit rd_at5, input int sop_glitch_at);
        logic [7:0] b [53];
        logic [7:0] good;
        bit         drop_cell;
        good = ref_hec(hdr);
        for (int i = 0; i < 4; i++) b[i] = hdr[8*(3-i) +: 8];
        b[4] = corrupt ? (good ^ (8'($urandom % 255) + 8'd1)) : good;
        for (int i = 5; i < 53; i++) b[i] = 8'($urandom);
        drop_cell = corrupt && (md != 2'b00);
        for (int i = 0; i < 53; i++) begin
            if ($urandom % 5 == 0) begin
                in_valid = 1'b0;
                in_sop   = 1'b1;
                step();
                chk("R1 gap", out_valid, 0);
            end
            in_valid = 1'b1;
            in_sop   = (i == 0) || (i == sop_glitch_at);
            in_port  = (i == 0) ? PW'(port) : PW'($urandom);
            in_data  = b[i];
            mode     = md;
            rd_en    = rd_at5 && (i == 4);
            rd_port  = PW'(port);
            step();
            rd_en = 1'b0;
            chk("R1 valid", out_valid, 1);
            chk("R2 sop", out_sop, (i == 0) ? 1 : 0);
            if (i == 4)
                chk((md == 2'b00) ? "R5 hec byte" : "R8 hec byte", out_data, (md == 2'b00) ? good : b[4]);
            else
                chk("R1 data", out_data, b[i]);
            chk((md == 2'b00) ? "R6 drop" : (corrupt ? "R8 drop" : "R9 drop"),
                out_drop, (drop_cell && i >= 4) ? 1 : 0);
            if (i == 4) begin
                if (rd_at5) begin
                    chk("R11 read", rd_count, model_cnt[port]);
                    model_cnt[port] = 0;
                end
                if (md == 2'b00 && corrupt && model_cnt[port] < MAXC)
                    model_cnt[port]++;
            end
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic read_cnt(input string req, input int port);
        rd_en   = 1'b1;
        rd_port = PW'(port);
        step();
        rd_en = 1'b0;
        chk(req, rd_count, model_cnt[port]);
        model_cnt[port] = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7622));
        for (int p = 0; p < NP; p++) model_cnt[p] = 0;
        rst = 1'b1; mode = 2'b00; in_valid = 1'b0; in_sop = 1'b0;
        in_port = '0; in_data = '0; rd_en = 1'b0; rd_port = '0;
        repeat (3) step();
        chk("R12 out_valid", out_valid, 0);
        rst = 1'b0;
        step();
        for (int p = 0; p < NP; p++) read_cnt("R12 counter", p);

        // R3: stray bytes with no start flag
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'($urandom);
            step();
            chk("R3 stray", out_valid, 0);
        end
        in_valid = 1'b0;

        // R4: known header gives 0x52
        chk("R4 ref", ref_hec(32'h00000001), 8'h52);
        send_cell(0, 2'b00, 32'h00000001, 1'b1, 1'b0, -1);
        send_cell(0, 2'b01, 32'h00000001, 1'b0, 1'b0, -1);
        read_cnt("R7 count", 0);

        // R2: start flag mid-cell is payload
        send_cell(3, 2'b10, 32'($urandom), 1'b0, 1'b0, 20);
        send_cell(3, 2'b11, 32'($urandom), 1'b1, 1'b0, 7);

        // R8 / R9: filtering modes leave counters untouched
        send_cell(1, 2'b01, 32'($urandom), 1'b1, 1'b0, -1);
        send_cell(1, 2'b10, 32'($urandom), 1'b0, 1'b0, -1);
        read_cnt("R8 counter", 1);

        // R7: good header in mode 00 does not count
        send_cell(2, 2'b00, 32'($urandom), 1'b0, 1'b0, -1);
        read_cnt("R7 no count", 2);

        // mixed random traffic
        for (int n = 0; n < 30; n++)
            send_cell($urandom % NP, 2'($urandom), 32'($urandom), ($urandom % 2) == 1, 1'b0, -1);
        for (int p = 0; p < NP; p++) read_cnt("R7 random", p);

        // R10: saturation
        for (int n = 0; n < 9; n++) send_cell(1, 2'b00, 32'($urandom), 1'b1, 1'b0, -1);
        read_cnt("R10 saturate", 1);
        read_cnt("R11 cleared", 1);

        // R11: read coincides with a new error
        send_cell(2, 2'b00, 32'($urandom), 1'b1, 1'b0, -1);
        send_cell(2, 2'b00, 32'($urandom), 1'b1, 1'b1, -1);
        read_cnt("R11 coincident", 2);

        for (int p = 0; p < NP; p++) read_cnt("R11 final", p);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule